// File: doc/BRIEF.md
# Strobe-Selected Serial Word Receiver

This block takes one serial line and a strobe line and turns them into one parallel word per frame. A frame begins when the frame sync input goes from low to high. Inside a frame the strobe may go high several times. Each high period frames one word, sent most significant bit first. The block counts the strobe periods, keeps only the word under the period chosen by a 4-bit select input, and ignores every other period until the next frame begins.

All inputs are sampled on the falling edge of the bit clock. A captured word is shown with a one-cycle valid pulse. A strobe period of the wrong length produces a one-cycle error pulse instead, and so does a strobe that is already high when the frame starts. In both cases the word is discarded. The transmit direction shares the two clocks with this block but is a separate design.

Top module: `strobe_word_rx`

## Requirements
- R1: Inputs are sampled on falling bit-clock edges. The first sample taken with the strobe high becomes bit 15 of the word, and each later sample fills the next lower bit.
- R2: A select value from 1 to 15 picks the strobe period of that number within the frame. A select value of 0 picks the 16th period.
- R3: `word_valid` is high for exactly one cycle. It rises at the first falling edge where the strobe is sampled low after exactly 16 high samples of the selected period. `word_out` then holds that word until the next word is delivered.
- R4: At most one word is delivered per frame. Strobe periods after the selected one cause neither a word nor an error.
- R5: The period count restarts at every frame start. A frame start is a sample with frame sync high when the previous sample had it low.
- R6: If the selected period is sampled high for fewer than 16 edges, `len_err` pulses when the strobe falls. If it is sampled high for more than 16 edges, `len_err` pulses at the 17th high sample. No word is delivered in either case.
- R7: If the strobe is high at the frame-start sample, `len_err` pulses once and the frame delivers no word.
- R8: After reset, strobe periods are ignored until the first frame start.
- R9: During reset and immediately after it, `word_out`, `word_valid` and `len_err` are all zero.
- R10: If the frame holds fewer strobe periods than the select value asks for, neither a word nor an error is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; the logic acts on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | Frame sync; a low-to-high transition starts a frame |
| ser_in | input | 1 | Serial data, MSB first |
| strobe_in | input | 1 | High while a word is on `ser_in` |
| pulse_sel | input | 4 | Chooses which strobe period to capture (0 means 16) |
| word_out | output | 16 | Last word captured |
| word_valid | output | 1 | One-cycle pulse when `word_out` is updated |
| len_err | output | 1 | One-cycle pulse on a bad selected period or a strobe high at frame start |

## Verification
The bench targets these corner cases:
- Select value 0 with sixteen periods in the frame. A design that decodes 0 literally would never deliver.
- Extra periods after the chosen one. A design that keeps counting would deliver twice or raise a false error.
- Selected periods of 12, 15 and 20 samples. A length check that is off by one would either accept a wrong word or reject a good one.
- A strobe already high at the frame edge, a frame that restarts the count part-way through, and periods arriving before the first frame. These catch a design that counts the held strobe as period 1, carries its count across frames, or listens straight after reset.
- The exact cycle of the valid pulse, and the word's bit order, are checked directly.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [1:0] {
    RX_WAIT  = 2'd0,
    RX_HUNT  = 2'd1,
    RX_SHIFT = 2'd2,
    RX_DONE  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/srx_edge_det.sv
module srx_edge_det (
  input  logic bclk,
  input  logic rst,
  input  logic frame_sync,
  input  logic strobe_in,
  output logic frame_rise,
  output logic strobe_rise
);
  logic fsc_q;
  logic stb_q;

  always_ff @(negedge bclk) begin
    if (rst) begin
      fsc_q <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      fsc_q <= frame_sync;
      stb_q <= strobe_in;
    end
  end

  assign frame_rise  = frame_sync & ~fsc_q;
  assign strobe_rise = strobe_in & ~stb_q;
endmodule

// File: rtl/srx_pulse_sel.sv
module srx_pulse_sel #(
  parameter int WORD_W = 16,
  parameter int SEL_W  = 4
) (
  input  logic             bclk,
  input  logic             rst,
  input  logic             frame_rise,
  input  logic             strobe_rise,
  input  logic             strobe_hi,
  input  logic [SEL_W-1:0] pulse_sel,
  output logic             shift_en,
  output logic             finish_ok,
  output logic             finish_bad
);
  import srx_pkg::*;

  localparam int LEN_W = $clog2(WORD_W + 1);
  localparam logic [LEN_W-1:0] LEN_FULL = LEN_W'(WORD_W);
  localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(1);
  localparam logic [SEL_W:0]   CNT_MAX  = {1'b1, {SEL_W{1'b0}}};
  localparam logic [SEL_W:0]   CNT_ONE  = {{SEL_W{1'b0}}, 1'b1};

  rx_state_e        state_q, state_d;
  logic [SEL_W:0]   cnt_q, cnt_d, cnt_inc, target;
  logic [LEN_W-1:0] len_q, len_d;

  assign target  = (pulse_sel == '0) ? CNT_MAX : {1'b0, pulse_sel};
  assign cnt_inc = cnt_q + CNT_ONE;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    len_d      = len_q;
    shift_en   = 1'b0;
    finish_ok  = 1'b0;
    finish_bad = 1'b0;
    unique case (state_q)
      RX_WAIT: ;
      RX_HUNT: begin
        if (strobe_rise) begin
          cnt_d = cnt_inc;
          if (cnt_inc == target) begin
            state_d  = RX_SHIFT;
            shift_en = 1'b1;
            len_d    = LEN_ONE;
          end
        end
      end
      RX_SHIFT: begin
        if (strobe_hi) begin
          if (len_q == LEN_FULL) begin
            finish_bad = 1'b1;
            state_d    = RX_DONE;
          end else begin
            shift_en = 1'b1;
            len_d    = len_q + LEN_ONE;
          end
        end else begin
          finish_ok  = (len_q == LEN_FULL);
          finish_bad = (len_q != LEN_FULL);
          state_d    = RX_DONE;
        end
      end
      RX_DONE: ;
      default: state_d = RX_WAIT;
    endcase
    if (frame_rise) begin
      cnt_d    = '0;
      shift_en = 1'b0;
      if (strobe_hi) begin
        finish_bad = 1'b1;
        state_d    = RX_DONE;
      end else begin
        state_d = RX_HUNT;
      end
    end
  end

  always_ff @(negedge bclk) begin
    if (rst) begin
      state_q <= RX_WAIT;
      cnt_q   <= '0;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
    end
  end

  a_r6_len_bound: assert property (@(negedge bclk) disable iff (rst)
    len_q <= LEN_FULL);

  a_r2_cnt_bound: assert property (@(negedge bclk) disable iff (rst)
    cnt_q <= CNT_MAX);

  a_r8_wait_until_frame: assert property (@(negedge bclk) disable iff (rst)
    (state_q == RX_WAIT) |-> (!shift_en && !finish_ok));
endmodule

// File: rtl/srx_shift_reg.sv
module srx_shift_reg #(
  parameter int WORD_W = 16
) (
  input  logic              bclk,
  input  logic              rst,
  input  logic              ser_in,
  input  logic              shift_en,
  input  logic              finish_ok,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid
);
  logic [WORD_W-1:0] sh_q;

  always_ff @(negedge bclk) begin
    if (rst) begin
      sh_q       <= '0;
      word_out   <= '0;
      word_valid <= 1'b0;
    end else begin
      if (shift_en) sh_q <= {sh_q[WORD_W-2:0], ser_in};
      if (finish_ok) word_out <= sh_q;
      word_valid <= finish_ok;
    end
  end

  a_r3_valid_single: assert property (@(negedge bclk) disable iff (rst)
    word_valid |=> !word_valid);
endmodule

// File: rtl/strobe_word_rx.sv
module strobe_word_rx #(
  parameter int WORD_W = 16,
  parameter int SEL_W  = 4
) (
  input  logic              bclk,
  input  logic              rst,
  input  logic              frame_sync,
  input  logic              ser_in,
  input  logic              strobe_in,
  input  logic [SEL_W-1:0]  pulse_sel,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid,
  output logic              len_err
);
  logic frame_rise, strobe_rise;
  logic shift_en, finish_ok, finish_bad;

  srx_edge_det edge_i (
    .bclk        (bclk),
    .rst         (rst),
    .frame_sync  (frame_sync),
    .strobe_in   (strobe_in),
    .frame_rise  (frame_rise),
    .strobe_rise (strobe_rise)
  );

  srx_pulse_sel #(.WORD_W(WORD_W), .SEL_W(SEL_W)) sel_i (
    .bclk        (bclk),
    .rst         (rst),
    .frame_rise  (frame_rise),
    .strobe_rise (strobe_rise),
    .strobe_hi   (strobe_in),
    .pulse_sel   (pulse_sel),
    .shift_en    (shift_en),
    .finish_ok   (finish_ok),
    .finish_bad  (finish_bad)
  );

  srx_shift_reg #(.WORD_W(WORD_W)) shift_i (
    .bclk       (bclk),
    .rst        (rst),
    .ser_in     (ser_in),
    .shift_en   (shift_en),
    .finish_ok  (finish_ok),
    .word_out   (word_out),
    .word_valid (word_valid)
  );

  always_ff @(negedge bclk) begin
    if (rst) len_err <= 1'b0;
    else     len_err <= finish_bad;
  end

  // Checker state: has this frame already produced a word.
  logic got_q;
  always_ff @(negedge bclk) begin
    if (rst)             got_q <= 1'b0;
    else if (frame_rise) got_q <= 1'b0;
    else if (finish_ok)  got_q <= 1'b1;
  end

  a_r4_one_word_per_frame: assert property (@(negedge bclk) disable iff (rst)
    finish_ok |-> !got_q);

  a_r6_err_excludes_valid: assert property (@(negedge bclk) disable iff (rst)
    len_err |-> !word_valid);

  a_r3_valid_after_fall: assert property (@(negedge bclk) disable iff (rst)
    word_valid |-> (!$past(strobe_in) && $past(strobe_in, 2)));
endmodule

// File: tb/strobe_word_rx_tb_top.sv
module strobe_word_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 9;
  // Row fields: select [13:10], number of periods [9:5], selected length [4:0]
  localparam logic [13:0] ROWS [NROWS] = '{
    {4'd1,  5'd3,  5'd16},
    {4'd3,  5'd3,  5'd16},
    {4'd3,  5'd5,  5'd16},
    {4'd15, 5'd15, 5'd16},
    {4'd0,  5'd16, 5'd16},
    {4'd2,  5'd3,  5'd12},
    {4'd2,  5'd2,  5'd20},
    {4'd5,  5'd3,  5'd16},
    {4'd1,  5'd1,  5'd15}
  };

  logic        bclk = 1'b1;
  logic        rst = 1'b1;
  logic        frame_sync = 1'b0;
  logic        ser_in = 1'b0;
  logic        strobe_in = 1'b0;
  logic [3:0]  pulse_sel = 4'd1;
  logic [15:0] word_out;
  logic        word_valid;
  logic        len_err;

  int checks = 0;
  int errors = 0;
  int nvalid = 0;
  int nerr = 0;
  logic [15:0] last_word = '0;

  always #(CLK_PERIOD/2) bclk = ~bclk;

  strobe_word_rx dut_i (
    .bclk       (bclk),
    .rst        (rst),
    .frame_sync (frame_sync),
    .ser_in     (ser_in),
    .strobe_in  (strobe_in),
    .pulse_sel  (pulse_sel),
    .word_out   (word_out),
    .word_valid (word_valid),
    .len_err    (len_err)
  );

  // Outputs change on the falling edge; they are observed on the rising edge.
  always @(posedge bclk) begin
    if (word_valid) begin
      nvalid    <= nvalid + 1;
      last_word <= word_out;
    end
    if (len_err) nerr <= nerr + 1;
  end

  task automatic tick();
    @(posedge bclk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] word_of(input int r, input int p);
    return 16'(r * 16'h1357) ^ 16'(p * 16'h2468) ^ 16'h5A0F;
  endfunction

  task automatic frame_go();
    frame_sync = 1'b1;
    tick();
    tick();
    frame_sync = 1'b0;
    tick();
  endtask

  task automatic pulse(input logic [15:0] w, input int len);
    for (int i = 0; i < len; i++) begin
      strobe_in = 1'b1;
      ser_in    = (i < 16) ? w[15-i] : 1'b1;
      tick();
    end
    strobe_in = 1'b0;
    ser_in    = 1'b0;
    tick();
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v0, e0;
    // R9: reset state
    tick(); tick();
    check(word_out == 16'h0 && !word_valid && !len_err, "R9 outputs in reset",
          {word_out, 7'd0, word_valid, len_err}, 0);
    rst = 1'b0;
    tick();
    check(word_out == 16'h0 && !word_valid && !len_err, "R9 outputs after reset",
          {word_out, 7'd0, word_valid, len_err}, 0);

    // R8: periods before any frame start are ignored
    v0 = nvalid; e0 = nerr;
    pulse_sel = 4'd1;
    pulse(16'hBEEF, 16);
    pulse(16'h1234, 16);
    check(nvalid == v0 && nerr == e0, "R8 ignored before first frame",
          (nvalid - v0) + (nerr - e0), 0);

    // R1, R2, R4, R6, R10: vector table
    for (int r = 0; r < NROWS; r++) begin
      int sel, np, sl, tgt;
      bit exp_v, exp_e;
      sel = int'(ROWS[r][13:10]);
      np  = int'(ROWS[r][9:5]);
      sl  = int'(ROWS[r][4:0]);
      tgt = (sel == 0) ? 16 : sel;
      exp_v = (np >= tgt) && (sl == 16);
      exp_e = (np >= tgt) && (sl != 16);
      pulse_sel = 4'(sel);
      v0 = nvalid; e0 = nerr;
      frame_go();
      for (int p = 1; p <= np; p++) pulse(word_of(r, p), (p == tgt) ? sl : 16);
      tick();
      check((nvalid - v0) == int'(exp_v), "R2 R4 R10 word count", nvalid - v0, int'(exp_v));
      check((nerr - e0) == int'(exp_e), "R6 R10 error count", nerr - e0, int'(exp_e));
      if (exp_v)
        check(last_word == word_of(r, tgt), "R1 R2 captured word", last_word, word_of(r, tgt));
    end

    // R3: exact cycle of the valid pulse and held word
    pulse_sel = 4'd1;
    frame_go();
    for (int i = 0; i < 16; i++) begin
      strobe_in = 1'b1;
      ser_in    = (i == 0) || (i == 15);
      tick();
    end
    strobe_in = 1'b0;
    ser_in    = 1'b0;
    check(!word_valid, "R3 not valid during last bit", word_valid, 0);
    tick();
    check(word_valid && word_out == 16'h8001, "R3 R1 valid at first low sample",
          {word_out, 7'd0, word_valid}, {16'h8001, 8'd1});
    tick();
    check(!word_valid && word_out == 16'h8001, "R3 one cycle and word held",
          {word_out, 7'd0, word_valid}, {16'h8001, 8'd0});

    // R7: strobe high at the frame start
    pulse_sel = 4'd2;
    v0 = nvalid; e0 = nerr;
    strobe_in = 1'b1;
    tick();
    frame_sync = 1'b1;
    tick();
    tick();
    frame_sync = 1'b0;
    for (int i = 0; i < 14; i++) tick();
    strobe_in = 1'b0;
    tick(); tick();
    pulse(16'hCAFE, 16);
    pulse(16'hF00D, 16);
    tick();
    check((nerr - e0) == 1, "R7 error on strobe at frame start", nerr - e0, 1);
    check(nvalid == v0, "R7 frame delivers nothing", nvalid - v0, 0);

    // R5: count restarts with each frame
    pulse_sel = 4'd3;
    v0 = nvalid; e0 = nerr;
    frame_go();
    pulse(16'h1111, 16);
    pulse(16'h2222, 16);
    frame_go();
    pulse(16'h3333, 16);
    pulse(16'h4444, 16);
    check(nvalid == v0, "R5 no word from two-period count", nvalid - v0, 0);
    pulse(16'h5555, 16);
    tick();
    check((nvalid - v0) == 1 && last_word == 16'h5555, "R5 third period of new frame",
          last_word, 16'h5555);
    check(nerr == e0, "R5 no error", nerr - e0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule